// File: doc/BRIEF.md
# Two-Read Byte Multiplexed Result Port

This block holds a 13-bit conversion result (one sign bit plus a 12-bit magnitude) and hands it to an 8-bit host data bus over two successive read strobes. A read strobe is the interval in which both chip-select and read, each active low, are low. The first strobe after a result is latched returns the high byte. In that byte the sign bit is repeated across the top four bus bits. The second strobe returns the low byte. Any further strobes keep alternating between the high byte and the low byte.

The block keeps a one-bit pointer that names the next byte. The pointer advances on the clock edge that sees a strobe end, and it returns to the high byte whenever a new result is latched. An active-low interrupt goes low on the cycle after a result is latched and returns high when the first read strobe after that ends.

The bus itself is presented as a data vector and an output-enable. A pad-level tristate driver outside the block turns these into the high-impedance bus. The control inputs are taken as synchronous to the block clock.

Top module: `sar_result_port`

## Requirements
- R1: `db_oe_o` is 1 only in cycles where `cs_n_i` and `rd_n_i` are both 0. In every other cycle `db_oe_o` is 0 and `db_o` is all zeros.
- R2: The first read strobe after a result is latched returns the high byte.
- R3: The high byte has this layout: `db_o[2:0]` = result bits 10:8, `db_o[3]` = result bit 11 (the magnitude MSB), and `db_o[7:4]` each = result bit 12 (the sign, 1 meaning negative).
- R4: The low byte has this layout: `db_o[7:0]` = result bits 7:0, with bit 0 being the LSB.
- R5: The pointer advances at the clock edge where a strobe that was active in the previous cycle is no longer active. After the low byte it wraps back to the high byte.
- R6: A `res_valid_i` pulse latches `res_i` and sets the pointer to the high byte, even when it arrives between the two reads of a pair.
- R7: `irq_n_o` is 0 in the cycle after a `res_valid_i` pulse. It returns to 1 at the edge that ends the next read strobe.
- R8: Reads beyond the second keep alternating high, low, high, and so on, and the stored result stays unchanged until the next `res_valid_i`.
- R9: When `res_valid_i` and the end of a read strobe fall on the same edge, the latch takes precedence. The pointer goes to the high byte and `irq_n_o` goes to 0.
- R10: After reset, `irq_n_o` = 1, the pointer names the high byte, and the stored result is zero.
- R11: A strobe with `rd_n_i` low while `cs_n_i` is high is ignored. The bus is not enabled and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n_i | input | 1 | Chip-select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| res_valid_i | input | 1 | One-cycle pulse that latches a new result |
| res_i | input | 13 | Result: bit 12 is the sign, bits 11:0 are the magnitude |
| db_o | output | 8 | Bus data, zero while not enabled |
| db_oe_o | output | 1 | Bus output-enable for the external tristate driver |
| irq_n_o | output | 1 | Result-ready interrupt, active low |

## Verification
The latch of a new result and the end of a read strobe can land on the same clock edge. In that case both try to set the pointer and the interrupt. The bench provokes this by raising `res_valid_i` in the same cycle that it releases a strobe held over the low byte. It then judges the outcome from the ports: the interrupt must be low in the next cycle, and the following read must return the new result's high byte rather than the byte an advance would have selected.

// File: rtl/sarport_pkg.sv
package sarport_pkg;
  typedef enum logic {
    BYTE_HI = 1'b0,
    BYTE_LO = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/strobe_track.sv
module strobe_track (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic cs_n_i,
  input  logic rd_n_i,
  output logic rd_active_o,
  output logic rd_end_o
);
  logic act_q;
  logic act_d;

  assign rd_active_o = ~cs_n_i & ~rd_n_i;
  assign rd_end_o    = act_q & ~rd_active_o;

  always_comb begin
    act_d = rd_active_o;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) act_q <= 1'b0;
    else          act_q <= act_d;
  end
endmodule

// File: rtl/byte_ptr.sv
module byte_ptr
  import sarport_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  logic      load_i,
  input  logic      rd_end_i,
  output byte_sel_e sel_o
);
  byte_sel_e sel_q;
  byte_sel_e sel_d;
  logic      sel_en;

  always_comb begin
    sel_en = load_i | rd_end_i;
    if (load_i)              sel_d = BYTE_HI;
    else if (sel_q == BYTE_HI) sel_d = BYTE_LO;
    else                     sel_d = BYTE_HI;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    sel_q <= BYTE_HI;
    else if (sel_en) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  assert_load_resets_ptr_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |=> (sel_q == BYTE_HI));

  assert_ptr_toggles_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_end_i && !load_i) |=> (sel_q != $past(sel_q)));

  assert_ptr_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!rd_end_i && !load_i) |=> $stable(sel_q));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic load_i,
  input  logic rd_end_i,
  output logic irq_n_o
);
  logic irq_n_q;
  logic irq_n_d;
  logic irq_en;

  always_comb begin
    irq_en  = load_i | rd_end_i;
    irq_n_d = ~load_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    irq_n_q <= 1'b1;
    else if (irq_en) irq_n_q <= irq_n_d;
  end

  assign irq_n_o = irq_n_q;

  assert_irq_set_on_load_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |=> !irq_n_q);

  assert_irq_clear_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_end_i && !load_i) |=> irq_n_q);
endmodule

// File: rtl/byte_fmt.sv
module byte_fmt
  import sarport_pkg::*;
#(
  parameter int MAG_W = 12,
  parameter int BUS_W = 8,
  localparam int RES_W = MAG_W + 1,
  localparam int HI_W  = MAG_W - BUS_W,
  localparam int REP_W = BUS_W - HI_W
) (
  input  logic [RES_W-1:0] res_i,
  input  byte_sel_e        sel_i,
  input  logic             en_i,
  output logic [BUS_W-1:0] db_o
);
  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;

  assign hi_byte[HI_W-1:0] = res_i[MAG_W-1:BUS_W];

  for (genvar g = 0; g < REP_W; g++) begin : g_sign_rep
    assign hi_byte[HI_W+g] = res_i[MAG_W];
  end

  assign lo_byte = res_i[BUS_W-1:0];

  always_comb begin
    if (!en_i)                db_o = '0;
    else if (sel_i == BYTE_HI) db_o = hi_byte;
    else                      db_o = lo_byte;
  end
endmodule

// File: rtl/sar_result_port.sv
module sar_result_port
  import sarport_pkg::*;
#(
  parameter int MAG_W = 12,
  parameter int BUS_W = 8,
  localparam int RES_W = MAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             cs_n_i,
  input  logic             rd_n_i,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_i,
  output logic [BUS_W-1:0] db_o,
  output logic             db_oe_o,
  output logic             irq_n_o
);
  logic       rst_meta_q;
  logic       rst_n_s;
  logic       rd_active;
  logic       rd_end;
  byte_sel_e  sel;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] res_d;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  always_comb begin
    res_d = res_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)         res_q <= '0;
    else if (res_valid_i) res_q <= res_d;
  end

  strobe_track u_strobe (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_s),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .rd_active_o(rd_active),
    .rd_end_o   (rd_end)
  );

  byte_ptr u_ptr (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_s),
    .load_i  (res_valid_i),
    .rd_end_i(rd_end),
    .sel_o   (sel)
  );

  irq_ctrl u_irq (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_s),
    .load_i  (res_valid_i),
    .rd_end_i(rd_end),
    .irq_n_o (irq_n_o)
  );

  byte_fmt #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_fmt (
    .res_i(res_q),
    .sel_i(sel),
    .en_i (rd_active),
    .db_o (db_o)
  );

  assign db_oe_o = rd_active;

  assert_idle_bus_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !db_oe_o |-> (db_o == '0));

  assert_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !res_valid_i |=> $stable(res_q));

  assert_result_loaded_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    res_valid_i |=> (res_q == $past(res_i)));
endmodule

// File: tb/sar_result_port_tb.sv
module sar_result_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic        rd_n;
  logic        res_valid;
  logic [12:0] res;
  logic [7:0]  db;
  logic        db_oe;
  logic        irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         seen = 1'b0;

  always #4 clk = ~clk;

  sar_result_port dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .rd_n_i(rd_n),
    .res_valid_i(res_valid), .res_i(res), .db_o(db), .db_oe_o(db_oe),
    .irq_n_o(irq_n)
  );

  function automatic logic [7:0] hi_of(logic [12:0] r);
    // R3 layout: [2:0]=r[10:8], [3]=r[11], [7:4]=sign r[12]
    return {r[12], r[12], r[12], r[12], r[11], r[10], r[9], r[8]};
  endfunction

  function automatic logic [7:0] lo_of(logic [12:0] r);
    return r[7:0]; // R4
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare first cycle of each enabled strobe against the queue
  always @(negedge clk) begin
    if (db_oe && !seen) begin
      seen = 1'b1;
      if (exp_q.size() == 0) check(1'b0, "unexpected read", {24'd0, db}, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(db === e, t, {24'd0, db}, {24'd0, e});
      end
    end else if (!db_oe) begin
      seen = 1'b0;
    end
  end

  task automatic do_read(logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1; cs_n = 0; rd_n = 0;
    repeat (2) @(posedge clk);
    #1; cs_n = 1; rd_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic do_load(logic [12:0] v);
    @(posedge clk); #1; res_valid = 1; res = v;
    @(posedge clk); #1; res_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [12:0] a;
    logic [12:0] b;
    logic [12:0] c;
    logic [12:0] d;
    rst_n = 0; cs_n = 1; rd_n = 1; res_valid = 0; res = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq_n === 1'b1, "R10 irq after reset", {31'd0, irq_n}, 1);
    check(db_oe === 1'b0, "R10 bus idle after reset", {31'd0, db_oe}, 0);
    check(db === 8'h00, "R1 idle data zero", {24'd0, db}, 0);
    do_read(8'h00, "R10 high byte of reset result");
    do_read(8'h00, "R10 low byte of reset result");

    a = 13'h1A5C;
    do_load(a);
    @(negedge clk);
    check(irq_n === 1'b0, "R7 irq low after load", {31'd0, irq_n}, 0);
    do_read(hi_of(a), "R2 R3 negative high byte");
    @(negedge clk);
    check(irq_n === 1'b1, "R7 irq cleared by first read", {31'd0, irq_n}, 1);
    do_read(lo_of(a), "R4 low byte");
    do_read(hi_of(a), "R5 wrap to high byte");
    do_read(lo_of(a), "R8 extra read low byte unchanged");
    do_read(hi_of(a), "R8 third pair high byte");

    b = 13'h0ABC;
    do_load(b);
    @(posedge clk); #1; cs_n = 0; rd_n = 1;
    @(negedge clk);
    check(db_oe === 1'b0, "R1 cs low rd high no drive", {31'd0, db_oe}, 0);
    @(posedge clk); #1; cs_n = 1; rd_n = 0;
    @(negedge clk);
    check(db_oe === 1'b0, "R11 rd low cs high no drive", {31'd0, db_oe}, 0);
    @(posedge clk); #1; rd_n = 1;
    @(posedge clk); #1;
    do_read(hi_of(b), "R11 ignored strobe did not advance; R3 positive high");
    c = 13'h1F01;
    do_load(c);
    do_read(hi_of(c), "R6 load mid pair resets to high byte");
    do_read(lo_of(c), "R4 low byte after reload");

    // R9: read end and load on the same edge
    d = 13'h0123;
    do_read(hi_of(c), "R5 high byte before collision");
    exp_q.push_back(lo_of(c));
    tag_q.push_back("R9 low byte before collision");
    @(posedge clk); #1; cs_n = 0; rd_n = 0;
    repeat (2) @(posedge clk);
    #1; cs_n = 1; rd_n = 1; res_valid = 1; res = d;
    @(posedge clk); #1; res_valid = 0;
    @(negedge clk);
    check(irq_n === 1'b0, "R9 load wins irq low", {31'd0, irq_n}, 0);
    do_read(hi_of(d), "R9 load wins pointer high");
    do_read(lo_of(d), "R9 low byte of new result");

    for (int i = 0; i < 6; i++) begin
      logic [12:0] v;
      v = 13'((i * 13'h0537) ^ 13'h1249);
      do_load(v);
      do_read(hi_of(v), "R3 pattern high byte");
      do_read(lo_of(v), "R4 pattern low byte");
    end

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "R1 all expected reads driven", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule